// File: doc/BRIEF.md
# Per-Phase Deadtime and Cross-Conduction Interlock

This block sits between the filtered switching commands of one inverter leg and the gate enables of its two power switches. The upper and lower outputs each follow their own command, non-inverted and one clock later. The block makes sure that the two outputs are never on together. It also makes sure that whenever conduction passes from one switch to the other, or back to the same switch, both switches stay off for at least `DEAD_CYC` clock cycles.

If the controller already leaves a gap of `DEAD_CYC` cycles or more between its commands, the edges pass through with only the one-cycle register delay. A shorter gap is stretched to exactly `DEAD_CYC` cycles. The switch that holds the leg keeps it for as long as its own command stays high, and a request from the other side in that time is ignored. When both commands rise together on an idle leg, the conflict cannot be resolved, so neither switch is turned on.

A kill line from the surrounding protection logic forces both outputs off in the same cycle. It also restarts the gap count, so a full deadtime follows every kill. All pins are plain level signals. There is no data stream and no handshake. One instance is used per phase.

Top module: `deadtime_interlock`

## Requirements
- R1: While `rst_n` is low both outputs are 0. After `rst_n` is released with a command held high, that output turns on at the (`DEAD_CYC`+1)th rising clock edge that sees `rst_n` high.
- R2: An output that is on turns off at the first clock edge that samples its own command low, one cycle after the command falls.
- R3: `hi_gate` and `lo_gate` are never 1 in the same cycle.
- R4: While one output is on and its own command stays high, the other command has no effect: the owning output stays 1 and the other stays 0.
- R5: If both outputs are off and both commands are sampled high together, neither output turns on for as long as both commands stay high.
- R6: After an output turns off, no output turns on until both have been off for `DEAD_CYC` cycles. A command gap of G < `DEAD_CYC` cycles gives an output gap of exactly `DEAD_CYC` cycles.
- R7: A command gap of G >= `DEAD_CYC` cycles passes unchanged: the output rises one cycle after its command, and the output gap is G cycles.
- R8: The deadtime is the same for an upper-to-lower handover and a lower-to-upper handover.
- R9: `kill` = 1 forces both outputs to 0 in the same cycle. Once `kill` returns to 0, a commanded output turns on at the (`DEAD_CYC`+1)th clock edge, whatever the gap count was before the kill.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| hi_cmd | input | 1 | Filtered command for the upper switch, 1 = on |
| lo_cmd | input | 1 | Filtered command for the lower switch, 1 = on |
| kill | input | 1 | Protection shutdown, 1 = both outputs off at once |
| hi_gate | output | 1 | Upper switch gate enable, 1 = on |
| lo_gate | output | 1 | Lower switch gate enable, 1 = on |

## Verification
The handover is swept over every command gap from zero (one command falls as the other rises) up to three cycles beyond the deadtime, in both directions. The measured output gap must follow max(G, `DEAD_CYC`) exactly, which separates stretching from pass-through and exposes any off-by-one at the boundary G = `DEAD_CYC`. Separate patterns hold the owning command high while the opposing command pulses, raise both commands together on an idle leg, and apply kill both to a conducting leg and to an idle leg whose gap count is already full. These patterns tell first-come ownership apart from conflict blocking, and show that the count really restarts.

// File: rtl/dt_pkg.sv
package dt_pkg;

  // Which switch of the leg currently conducts.
  typedef enum logic [1:0] {
    OWN_NONE = 2'b00,
    OWN_HI   = 2'b01,
    OWN_LO   = 2'b10
  } owner_e;

  // Width of a counter that must reach the value lim.
  function automatic int cnt_width(input int lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

endpackage

// File: rtl/dt_gap_timer.sv
// Counts cycles spent with both switches off, saturating at the deadtime.
module dt_gap_timer #(
  parameter int DEAD_CYC = 115
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,      // restart from zero (kill)
  input  logic restart,    // an output fell this edge: first off cycle begins
  input  logic count_en,   // both switches off
  output logic gap_ok
);
  localparam int CW = dt_pkg::cnt_width(DEAD_CYC);
  localparam logic [CW-1:0] LIMIT = CW'(DEAD_CYC);
  localparam logic [CW-1:0] ONE   = CW'(1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= ONE;
    end else if (count_en && (cnt_q != LIMIT)) begin
      cnt_q <= cnt_q + ONE;
    end
  end

  assign gap_ok = (cnt_q == LIMIT);

endmodule

// File: rtl/dt_owner_arb.sv
// Next-owner decision: first come keeps the leg; a simultaneous request
// from an idle leg is refused; a new owner needs a completed gap.
module dt_owner_arb
  import dt_pkg::*;
(
  input  owner_e owner_q,
  input  logic   hi_cmd,
  input  logic   lo_cmd,
  input  logic   gap_ok,
  output owner_e owner_d,
  output logic   released
);
  always_comb begin
    owner_d = owner_q;
    unique case (owner_q)
      OWN_HI: owner_d = hi_cmd ? OWN_HI : OWN_NONE;
      OWN_LO: owner_d = lo_cmd ? OWN_LO : OWN_NONE;
      default: begin
        if (gap_ok && hi_cmd && !lo_cmd) begin
          owner_d = OWN_HI;
        end else if (gap_ok && lo_cmd && !hi_cmd) begin
          owner_d = OWN_LO;
        end else begin
          owner_d = OWN_NONE;
        end
      end
    endcase
  end

  assign released = (owner_q != OWN_NONE) && (owner_d == OWN_NONE);

endmodule

// File: rtl/deadtime_interlock.sv
module deadtime_interlock
  import dt_pkg::*;
#(
  parameter int DEAD_CYC = 115  // minimum both-off cycles, must be >= 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_cmd,
  input  logic lo_cmd,
  input  logic kill,
  output logic hi_gate,
  output logic lo_gate
);
  localparam int SIDES = 2;

  owner_e owner_q;
  owner_e owner_d;
  logic   released;
  logic   gap_ok;
  logic   idle;
  logic [SIDES-1:0] gate_w;

  dt_owner_arb u_arb (
    .owner_q  (owner_q),
    .hi_cmd   (hi_cmd),
    .lo_cmd   (lo_cmd),
    .gap_ok   (gap_ok),
    .owner_d  (owner_d),
    .released (released)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || kill) begin
      owner_q <= OWN_NONE;
    end else begin
      owner_q <= owner_d;
    end
  end

  assign idle = (owner_q == OWN_NONE);

  dt_gap_timer #(.DEAD_CYC(DEAD_CYC)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (kill),
    .restart  (released),
    .count_en (idle),
    .gap_ok   (gap_ok)
  );

  // One gate driver per side; kill masks the registered owner at once.
  for (genvar s = 0; s < SIDES; s++) begin : g_side
    localparam owner_e SIDE_CODE = (s == 0) ? OWN_HI : OWN_LO;
    assign gate_w[s] = (owner_q == SIDE_CODE) && !kill;
  end

  assign hi_gate = gate_w[0];
  assign lo_gate = gate_w[1];

endmodule

// File: rtl/dt_interlock_chk.sv
module dt_interlock_chk #(
  parameter int DEAD_CYC = 115
) (
  input logic clk,
  input logic rst_n,
  input logic hi_cmd,
  input logic lo_cmd,
  input logic kill,
  input logic hi_gate,
  input logic lo_gate
);
  localparam int CW = dt_pkg::cnt_width(DEAD_CYC);
  localparam logic [CW-1:0] LIMIT = CW'(DEAD_CYC);

  // Independent count of consecutive both-off cycles seen at the outputs.
  logic [CW-1:0] off_run;
  always_ff @(posedge clk) begin
    if (!rst_n || hi_gate || lo_gate) begin
      off_run <= '0;
    end else if (off_run != LIMIT) begin
      off_run <= off_run + CW'(1);
    end
  end

  // R3
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_gate && lo_gate));

  // R6
  hi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_gate) |-> (off_run == LIMIT));

  // R8
  lo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_gate) |-> (off_run == LIMIT));

  // R2
  hi_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hi_gate) |-> (kill || !$past(hi_cmd)));

  // R4
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hi_gate && hi_cmd) && !kill) |-> (hi_gate && !lo_gate));

  // R4
  lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lo_gate && lo_cmd) && !kill) |-> (lo_gate && !hi_gate));

  // R5
  tie_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!hi_gate && !lo_gate && hi_cmd && lo_cmd) |-> (!hi_gate && !lo_gate));

  // R9
  kill_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill |-> (!hi_gate && !lo_gate));

endmodule

bind deadtime_interlock dt_interlock_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .hi_cmd  (hi_cmd),
  .lo_cmd  (lo_cmd),
  .kill    (kill),
  .hi_gate (hi_gate),
  .lo_gate (lo_gate)
);

// File: tb/test_deadtime_interlock.sv
module test_deadtime_interlock;
  localparam int D = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hi_cmd = 1'b0;
  logic lo_cmd = 1'b0;
  logic kill = 1'b0;
  logic hi_gate;
  logic lo_gate;

  int n_chk = 0;
  int n_fail = 0;
  int overlap_seen = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  deadtime_interlock #(.DEAD_CYC(D)) i_deadtime_interlock (
    .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
    .kill(kill), .hi_gate(hi_gate), .lo_gate(lo_gate)
  );

  always @(negedge clk) if (rst_n && hi_gate && lo_gate) overlap_seen++;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic gate_of(input bit hi);
    return hi ? hi_gate : lo_gate;
  endfunction

  task automatic set_cmd(input bit hi, input logic v);
    if (hi) hi_cmd = v; else lo_cmd = v;
  endtask

  // Ticks until the chosen gate is high; returns the number of ticks.
  task automatic ticks_to_rise(input bit hi, output int n);
    n = 0;
    do begin
      tick();
      n++;
    end while (!gate_of(hi) && n < 60);
  endtask

  task automatic idle_leg();
    hi_cmd = 1'b0;
    lo_cmd = 1'b0;
    repeat (D + 2) tick();
  endtask

  initial begin
    int n;
    #1;
    // R1: reset state and first turn-on
    repeat (3) tick();
    chk("R1 reset hi_gate", hi_gate, 0);
    chk("R1 reset lo_gate", lo_gate, 0);
    hi_cmd = 1'b1;
    rst_n = 1'b1;
    ticks_to_rise(1'b1, n);
    chk("R1 edges to first turn-on", n, D + 1);
    idle_leg();

    // R6/R7/R8: handover sweep over command gaps, both directions
    for (int dir = 0; dir < 2; dir++) begin
      for (int g = 0; g <= D + 3; g++) begin
        bit first_hi;
        first_hi = (dir == 0);
        set_cmd(first_hi, 1'b1);
        tick();
        chk($sformatf("R7 turn-on latency dir%0d g%0d", dir, g), gate_of(first_hi), 1);
        repeat (3) tick();
        chk($sformatf("R2 held on dir%0d g%0d", dir, g), gate_of(first_hi), 1);
        set_cmd(first_hi, 1'b0);
        if (g == 0) set_cmd(!first_hi, 1'b1);
        tick();
        n = 1;
        chk($sformatf("R2 turn-off latency dir%0d g%0d", dir, g), gate_of(first_hi), 0);
        while (n < g) begin
          tick();
          n++;
        end
        if (g > 0) set_cmd(!first_hi, 1'b1);
        while (!gate_of(!first_hi) && n < 60) begin
          tick();
          n++;
        end
        chk($sformatf("%s handover gap dir%0d g%0d", (g < D) ? "R6" : "R7", dir, g),
            n, ((g > D) ? g : D) + 1);
        if (dir == 1)
          chk($sformatf("R8 lower-to-upper matches g%0d", g), n, ((g > D) ? g : D) + 1);
        set_cmd(!first_hi, 1'b0);
        tick();
        chk($sformatf("R2 second off dir%0d g%0d", dir, g), gate_of(!first_hi), 0);
        idle_leg();
      end
    end

    // R4: owner keeps the leg while the other side requests
    for (int dir = 0; dir < 2; dir++) begin
      bit own_hi;
      own_hi = (dir == 0);
      set_cmd(own_hi, 1'b1);
      tick();
      set_cmd(!own_hi, 1'b1);
      for (int k = 0; k < 4; k++) begin
        tick();
        chk($sformatf("R4 owner dir%0d k%0d", dir, k), gate_of(own_hi), 1);
        chk($sformatf("R4 intruder dir%0d k%0d", dir, k), gate_of(!own_hi), 0);
      end
      idle_leg();
    end

    // R5: simultaneous request on an idle leg is refused
    hi_cmd = 1'b1;
    lo_cmd = 1'b1;
    for (int k = 0; k < 4; k++) begin
      tick();
      chk($sformatf("R5 tie both off k%0d", k), {30'd0, hi_gate, lo_gate}, 0);
    end
    lo_cmd = 1'b0;
    tick();
    chk("R5 tie resolves after lower drops", hi_gate, 1);
    idle_leg();

    // R9: kill on a conducting leg
    hi_cmd = 1'b1;
    tick();
    chk("R9 pre-kill on", hi_gate, 1);
    kill = 1'b1;
    #1;
    chk("R9 kill same cycle", hi_gate, 0);
    tick();
    chk("R9 kill held", hi_gate, 0);
    kill = 1'b0;
    ticks_to_rise(1'b1, n);
    chk("R9 restart after kill (busy leg)", n, D + 1);
    idle_leg();

    // R9: kill on an idle leg restarts a full gap count
    kill = 1'b1;
    tick();
    kill = 1'b0;
    lo_cmd = 1'b1;
    ticks_to_rise(1'b0, n);
    chk("R9 restart after kill (idle leg)", n, D + 1);
    idle_leg();

    chk("R3 overlap cycles", overlap_seen, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    done = 1'b1;
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1-to-R9 run: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule